// File: doc/BRIEF.md
# Sixteen-bit two-level carry lookahead adder

This block adds two 16-bit operands and a carry-in without any stored state, and returns the sum together with the carry-out. The operands are cut into four slices of four bits. Each slice builds a generate term and a propagate term for every bit. It then derives all of its internal carries straight from its own carry-in through expanded sum-of-products terms. No carry ripples from one bit to the next.

Each slice also reports a single generate term and a single propagate term for the whole slice. A shared second-level lookahead unit turns these four pairs and the block carry-in into the carry-in of every slice and into the final carry-out. Neither level looks across more than four inputs, which keeps the gate fan-in small.

The block also exports a generate and a propagate term for all 16 bits. A wider adder can therefore feed this block into a third lookahead level. The block has no clock and no handshake: its outputs follow its inputs after the combinational delay.

Top module: `cla16_adder`

## Requirements
- R1: `sum` equals the low 16 bits of `a + b + cin`, with the operands taken as unsigned numbers.
- R2: `cout` equals bit 16 of the 17-bit unsigned result of `a + b + cin`.
- R3: A carry that enters a slice from the slice below reaches the correct sum bits. Example: `a=16'h000F`, `b=16'h0001`, `cin=0` gives `sum=16'h0010`. The same holds at the 8-bit and 12-bit slice boundaries.
- R4: `blk_gen` is 1 exactly when `a + b`, with the carry-in left out, is at least 2^16.
- R5: `blk_prop` is 1 exactly when every bit of `a XOR b` is 1.
- R6: `blk_gen` and `blk_prop` are never both 1.
- R7: The carry-in travels through all four slices. With `a=16'hFFFF`, `b=16'h0000` and `cin=1`, the result is `sum=16'h0000` and `cout=1`. With `cin=0`, the same operands give `sum=16'hFFFF` and `cout=0`.
- R8: The corner cases give the expected results. All-ones plus all-ones with `cin=1` gives `sum=16'hFFFF` and `cout=1`. Zero plus zero with `cin=0` gives `sum=0`, `cout=0`, `blk_gen=0` and `blk_prop=0`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | 16 | First operand, unsigned |
| b | input | 16 | Second operand, unsigned |
| cin | input | 1 | Carry into bit 0 |
| sum | output | 16 | Low 16 bits of the result |
| cout | output | 1 | Carry out of bit 15 |
| blk_gen | output | 1 | Generate term for all 16 bits, for a further lookahead level |
| blk_prop | output | 1 | Propagate term for all 16 bits, for a further lookahead level |

## Verification
The assertions are immediate checks on the settled outputs. They assume the inputs are known two-state values that stay constant while the outputs are compared. The bench meets this by changing the operands only on the falling clock edge and reading the outputs a quarter period later, when no other input is changing. The stimulus includes the operand patterns that stress the slice boundaries and the two outer corners. Bench-computed results are used as the reference.

// File: rtl/cla_pkg.sv
package cla_pkg;
  localparam int unsigned CLA_MAX_FANIN = 4;
  localparam int unsigned CLA_DEF_WIDTH = 16;
  localparam int unsigned CLA_DEF_GROUP = 4;
endpackage

// File: rtl/cla_pg_cell.sv
module cla_pg_cell (
  input  logic a_i,
  input  logic b_i,
  output logic gen_o,
  output logic prop_o
);
  assign gen_o  = a_i & b_i;
  assign prop_o = a_i ^ b_i;
endmodule

// File: rtl/cla_lookahead.sv
// Expanded-product lookahead over N generate/propagate pairs.
// carry_o[0] is the incoming carry; carry_o[j] is the carry into position j.
module cla_lookahead #(
  parameter int unsigned N = cla_pkg::CLA_MAX_FANIN
) (
  input  logic [N-1:0] gen_i,
  input  logic [N-1:0] prop_i,
  input  logic         cin_i,
  output logic [N-1:0] carry_o,
  output logic         blk_gen_o,
  output logic         blk_prop_o
);
  logic term;

  always_comb begin
    carry_o    = '0;
    carry_o[0] = cin_i;
    term       = 1'b0;
    for (int j = 1; j < int'(N); j++) begin
      // term carried in from below, propagated through every lower position
      term = cin_i;
      for (int m = 0; m < j; m++) term = term & prop_i[m];
      carry_o[j] = term;
      // each lower position generating, propagated through those above it
      for (int k = 0; k < j; k++) begin
        term = gen_i[k];
        for (int m = k + 1; m < j; m++) term = term & prop_i[m];
        carry_o[j] = carry_o[j] | term;
      end
    end
    blk_prop_o = &prop_i;
    blk_gen_o  = 1'b0;
    for (int k = 0; k < int'(N); k++) begin
      term = gen_i[k];
      for (int m = k + 1; m < int'(N); m++) term = term & prop_i[m];
      blk_gen_o = blk_gen_o | term;
    end
  end
endmodule

// File: rtl/cla_group.sv
// One slice: per-bit pg cells, first-level lookahead, sum bits.
module cla_group #(
  parameter int unsigned W = cla_pkg::CLA_DEF_GROUP
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o,
  output logic         grp_gen_o,
  output logic         grp_prop_o
);
  logic [W-1:0] gen_w;
  logic [W-1:0] prop_w;
  logic [W-1:0] carry_w;

  for (genvar i = 0; i < int'(W); i++) begin : g_bit
    cla_pg_cell u_pg (
      .a_i    (a_i[i]),
      .b_i    (b_i[i]),
      .gen_o  (gen_w[i]),
      .prop_o (prop_w[i])
    );
  end

  cla_lookahead #(.N(W)) u_la (
    .gen_i      (gen_w),
    .prop_i     (prop_w),
    .cin_i      (cin_i),
    .carry_o    (carry_w),
    .blk_gen_o  (grp_gen_o),
    .blk_prop_o (grp_prop_o)
  );

  assign sum_o = prop_w ^ carry_w;
endmodule

// File: rtl/cla16_adder.sv
module cla16_adder #(
  parameter int unsigned WIDTH   = cla_pkg::CLA_DEF_WIDTH,
  parameter int unsigned GROUP_W = cla_pkg::CLA_DEF_GROUP
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             cin,
  output logic [WIDTH-1:0] sum,
  output logic             cout,
  output logic             blk_gen,
  output logic             blk_prop
);
  localparam int unsigned NUM_GRP = WIDTH / GROUP_W;

  logic [NUM_GRP-1:0] grp_gen;
  logic [NUM_GRP-1:0] grp_prop;
  logic [NUM_GRP-1:0] grp_cin;

  for (genvar g = 0; g < int'(NUM_GRP); g++) begin : g_grp
    cla_group #(.W(GROUP_W)) u_grp (
      .a_i        (a[g*GROUP_W +: GROUP_W]),
      .b_i        (b[g*GROUP_W +: GROUP_W]),
      .cin_i      (grp_cin[g]),
      .sum_o      (sum[g*GROUP_W +: GROUP_W]),
      .grp_gen_o  (grp_gen[g]),
      .grp_prop_o (grp_prop[g])
    );
  end

  // second level: carries into every slice straight from cin
  cla_lookahead #(.N(NUM_GRP)) u_la2 (
    .gen_i      (grp_gen),
    .prop_i     (grp_prop),
    .cin_i      (cin),
    .carry_o    (grp_cin),
    .blk_gen_o  (blk_gen),
    .blk_prop_o (blk_prop)
  );

  assign cout = blk_gen | (blk_prop & cin);
endmodule

// File: rtl/cla_adder_checker.sv
module cla_adder_checker #(
  parameter int unsigned WIDTH = cla_pkg::CLA_DEF_WIDTH
) (
  input logic [WIDTH-1:0] a,
  input logic [WIDTH-1:0] b,
  input logic             cin,
  input logic [WIDTH-1:0] sum,
  input logic             cout,
  input logic             blk_gen,
  input logic             blk_prop
);
  logic [WIDTH:0] ref_full;
  logic [WIDTH:0] ref_nocin;

  always_comb begin
    ref_nocin = {1'b0, a} + {1'b0, b};
    ref_full  = ref_nocin + {{WIDTH{1'b0}}, cin};
    a_r1_sum_value : assert (sum == ref_full[WIDTH-1:0]);
    a_r2_carry_out : assert (cout == ref_full[WIDTH]);
    a_r4_block_gen : assert (blk_gen == ref_nocin[WIDTH]);
    a_r5_block_prop: assert (blk_prop == &(a ^ b));
    a_r6_gp_exclusive: assert (!(blk_gen && blk_prop));
  end
endmodule

bind cla16_adder cla_adder_checker #(.WIDTH(WIDTH)) u_chk (
  .a(a), .b(b), .cin(cin), .sum(sum), .cout(cout),
  .blk_gen(blk_gen), .blk_prop(blk_prop)
);

// File: tb/test_cla16_adder.sv
module test_cla16_adder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] a = '0;
  logic [15:0] b = '0;
  logic        cin = 1'b0;
  logic [15:0] sum;
  logic        cout;
  logic        blk_gen;
  logic        blk_prop;
  int          checks = 0;
  int          errors = 0;
  int          cycles = 0;

  always #10 clk = ~clk;

  cla16_adder i_cla16_adder (
    .a(a), .b(b), .cin(cin), .sum(sum), .cout(cout),
    .blk_gen(blk_gen), .blk_prop(blk_prop)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      errors = errors + 1;
      $display("FAIL watchdog: actual %0d cycles expected under 100000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic apply(input logic [15:0] av, input logic [15:0] bv, input logic ci);
    @(negedge clk);
    a = av; b = bv; cin = ci;
    #5;
  endtask

  // compares all outputs against the arithmetic reference
  task automatic check_all(input string req);
    logic [16:0] full;
    logic [16:0] nocin;
    nocin = {1'b0, a} + {1'b0, b};
    full  = nocin + {16'd0, cin};
    checks++;
    if (sum !== full[15:0]) begin
      errors++;
      $display("FAIL %s R1 sum: actual %h expected %h", req, sum, full[15:0]);
    end
    checks++;
    if (cout !== full[16]) begin
      errors++;
      $display("FAIL %s R2 cout: actual %b expected %b", req, cout, full[16]);
    end
    checks++;
    if (blk_gen !== nocin[16]) begin
      errors++;
      $display("FAIL %s R4 blk_gen: actual %b expected %b", req, blk_gen, nocin[16]);
    end
    checks++;
    if (blk_prop !== (&(a ^ b))) begin
      errors++;
      $display("FAIL %s R5 blk_prop: actual %b expected %b", req, blk_prop, &(a ^ b));
    end
    checks++;
    if (blk_gen && blk_prop) begin
      errors++;
      $display("FAIL %s R6 exclusive: actual gen=%b prop=%b expected not both 1", req, blk_gen, blk_prop);
    end
  endtask

  task automatic t_reset_state;
    #5;
    checks++;
    if (sum !== 16'h0000 || cout !== 1'b0) begin
      errors++;
      $display("FAIL reset R8: actual %b_%h expected 0_0000", cout, sum);
    end
  endtask

  task automatic t_corners;
    apply(16'h0000, 16'h0000, 1'b0);
    check_all("R8 zero");
    checks++;
    if (sum !== 16'h0000 || cout || blk_gen || blk_prop) begin
      errors++;
      $display("FAIL R8 zero: actual %b_%h expected 0_0000", cout, sum);
    end
    apply(16'hFFFF, 16'hFFFF, 1'b1);
    check_all("R8 ones");
    checks++;
    if (sum !== 16'hFFFF || cout !== 1'b1) begin
      errors++;
      $display("FAIL R8 ones: actual %b_%h expected 1_ffff", cout, sum);
    end
  endtask

  task automatic t_full_propagate;
    apply(16'hFFFF, 16'h0000, 1'b1);
    check_all("R7 cin1");
    checks++;
    if (sum !== 16'h0000 || cout !== 1'b1) begin
      errors++;
      $display("FAIL R7 cin1: actual %b_%h expected 1_0000", cout, sum);
    end
    apply(16'hFFFF, 16'h0000, 1'b0);
    check_all("R7 cin0");
    checks++;
    if (sum !== 16'hFFFF || cout !== 1'b0) begin
      errors++;
      $display("FAIL R7 cin0: actual %b_%h expected 0_ffff", cout, sum);
    end
  endtask

  task automatic t_boundaries;
    for (int g = 0; g < 3; g++) begin
      logic [15:0] ones;
      logic [15:0] expv;
      ones = 16'hFFFF >> (12 - 4 * g);
      expv = 16'h0001 << (4 * g + 4);
      apply(ones, 16'h0001, 1'b0);
      check_all("R3 boundary");
      checks++;
      if (sum !== expv) begin
        errors++;
        $display("FAIL R3 boundary %0d: actual %h expected %h", g, sum, expv);
      end
    end
  endtask

  task automatic t_random;
    for (int i = 0; i < 400; i++) begin
      apply(16'($urandom), 16'($urandom), 1'($urandom));
      check_all("R1 R2 random");
    end
  endtask

  task automatic t_gen_prop;
    apply(16'h8000, 16'h8000, 1'b0);
    check_all("R4 gen msb");
    apply(16'hA5A5, 16'h5A5A, 1'b0);
    check_all("R5 prop all");
    apply(16'hA5A5, 16'h5A5A, 1'b1);
    check_all("R5 prop cin");
  endtask

  initial begin
    t_reset_state();
    repeat (2) @(posedge clk);
    rst_n = 1'b1;
    t_corners();
    t_full_propagate();
    t_boundaries();
    t_gen_prop();
    t_random();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule